// File: doc/BRIEF.md
# Receive Framing Error Monitor

This block sits behind a 128b/130b receive block decoder and watches the sequence of blocks, tokens and PHY status it reports. It follows the data stream with a three-state tracker (idle, streaming, end-of-stream pending) and checks that blocks are ordered legally around stream start, stream end and skip boundaries. Each kind of violation, plus PHY errors inside a packet and loss of block alignment, latches its own sticky bit in a 32-bit status word.

Software reads the status word through a plain address/read/write port and clears individual bits by writing ones to them. The decoder supplies one strobe per block with its sync header and ordered-set kind, single-cycle pulses for an end-of-stream token and for an invalid token, the PHY valid and status lines, and a flag that is high while a packet is being received.

Top module: `rx_frame_err_mon`

## Requirements
- R1: After reset all status bits are 0. Reading address `STATUS_OFFSET` (default 0x238) returns bits 8:0 of status with bits 31:9 as 0; any other address reads as 0. A status bit set by a condition in cycle N is visible on `reg_rdata` after the clock edge ending cycle N.
- R2: A write to `STATUS_OFFSET` clears each status bit whose `reg_wdata` bit is 1; if a condition sets that bit in the same cycle, the bit stays set. Writes to other addresses change nothing.
- R3: A block start with sync header 2'b00 or 2'b11 sets bit 7 and returns the tracker to idle.
- R4: Sync header 2'b01 marks a data block and 2'b10 an ordered-set block; `blk_os` encodes SKP=0, EIOS=1, EIEOS=2, SDS=3, any other kind=4. An SDS block in idle starts the stream; an end-of-stream pulse in a cycle with no block start moves a running stream to end-pending; any error in bits 8:1 returns the tracker to idle.
- R5: In end-pending, an EIOS, EIEOS or SKP block is legal and returns the tracker to idle without error; any other ordered-set kind sets bit 2.
- R6: A data block in end-pending sets bit 3.
- R7: During a running stream, an SDS block sets bit 6 and any other ordered-set block sets bit 4.
- R8: An ordered-set block whose previous block was a SKP ordered set sets bit 1; a data block after SKP raises no error.
- R9: An invalid-token pulse while `in_tlp` is high and the stream is running sets bit 5; outside a running stream it has no effect.
- R10: `rx_valid` falling from 1 to 0 while the stream is running sets bit 8; a fall in idle has no effect.
- R11: `rx_status` values 4 to 7 while `in_tlp` is high set bit 0 in any tracker state; with `in_tlp` low they have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | First cycle of a received block |
| blk_sync | input | 2 | Sync header of the block |
| blk_os | input | 3 | Ordered-set kind of the block |
| eds_tok | input | 1 | End-of-stream token pulse |
| bad_tok | input | 1 | Invalid framing token pulse |
| rx_valid | input | 1 | PHY receive valid |
| rx_status | input | 3 | PHY receive status |
| in_tlp | input | 1 | High while a packet is being received |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |

## Verification
The bench builds the block with its defaults: a 12-bit address, a 32-bit data word and the status at 0x238. With these values the neighbouring address 0x23C can be used to show that a foreign read returns 0 and a foreign write clears nothing, and the 23 reserved bits above the nine status bits can be checked to stay 0. The vector table then walks the tracker through every legal and illegal transition around SDS, EDS and SKP, including a clear that collides with a set.

// File: rtl/rxfm_pkg.sv
package rxfm_pkg;

    localparam int ERR_BITS = 9;

    // status bit positions
    localparam int B_PHY_ERR      = 0;
    localparam int B_OS_AFTER_SKP = 1;
    localparam int B_BAD_OS_EDS   = 2;
    localparam int B_DATA_EDS     = 3;
    localparam int B_OS_NO_EDS    = 4;
    localparam int B_BAD_TOKEN    = 5;
    localparam int B_SDS_TWICE    = 6;
    localparam int B_BAD_SYNC     = 7;
    localparam int B_ALIGN_LOST   = 8;

    localparam logic [1:0] SYNC_DATA = 2'b01;
    localparam logic [1:0] SYNC_OS   = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_ENDING = 2'd2
    } strm_state_e;

    typedef enum logic [2:0] {
        OS_SKP   = 3'd0,
        OS_EIOS  = 3'd1,
        OS_EIEOS = 3'd2,
        OS_SDS   = 3'd3,
        OS_OTHER = 3'd4
    } os_kind_e;

    typedef struct packed {
        logic       start;
        logic [1:0] sync;
        os_kind_e   os;
        logic       eds;
        logic       bad_tok;
    } blk_evt_t;

    function automatic logic sync_legal(input logic [1:0] s);
        return (s == SYNC_DATA) || (s == SYNC_OS);
    endfunction

    function automatic logic legal_after_end(input os_kind_e k);
        return (k == OS_SKP) || (k == OS_EIOS) || (k == OS_EIEOS);
    endfunction

    function automatic logic phy_fault(input logic [2:0] st);
        return st[2];
    endfunction

endpackage

// File: rtl/rxfm_tracker.sv
module rxfm_tracker
    import rxfm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  blk_evt_t            ev,
    input  logic                rx_valid,
    input  logic [2:0]          rx_status,
    input  logic                in_tlp,
    output logic [ERR_BITS-1:0] set_vec,
    output strm_state_e         state_q
);

    strm_state_e state_d;
    logic        skp_q, skp_d;
    logic        vld_q;
    logic        is_os, is_data, framing;

    always_comb begin
        is_os   = ev.start && (ev.sync == SYNC_OS);
        is_data = ev.start && (ev.sync == SYNC_DATA);

        set_vec = '0;
        if (ev.start && !sync_legal(ev.sync))
            set_vec[B_BAD_SYNC] = 1'b1;
        if (is_data && state_q == ST_ENDING)
            set_vec[B_DATA_EDS] = 1'b1;
        if (is_os && skp_q)
            set_vec[B_OS_AFTER_SKP] = 1'b1;
        if (is_os && state_q == ST_ENDING && !legal_after_end(ev.os))
            set_vec[B_BAD_OS_EDS] = 1'b1;
        if (is_os && state_q == ST_STREAM) begin
            if (ev.os == OS_SDS)
                set_vec[B_SDS_TWICE] = 1'b1;
            else
                set_vec[B_OS_NO_EDS] = 1'b1;
        end
        if (ev.bad_tok && in_tlp && state_q == ST_STREAM)
            set_vec[B_BAD_TOKEN] = 1'b1;
        if (vld_q && !rx_valid && state_q == ST_STREAM)
            set_vec[B_ALIGN_LOST] = 1'b1;
        if (in_tlp && phy_fault(rx_status))
            set_vec[B_PHY_ERR] = 1'b1;

        framing = |set_vec[ERR_BITS-1:1];

        state_d = state_q;
        if (framing) begin
            state_d = ST_IDLE;
        end else if (is_os) begin
            case (state_q)
                ST_IDLE:   state_d = (ev.os == OS_SDS) ? ST_STREAM : ST_IDLE;
                ST_ENDING: state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end else if (ev.eds && !ev.start && state_q == ST_STREAM) begin
            state_d = ST_ENDING;
        end

        skp_d = skp_q;
        if (ev.start)
            skp_d = is_os && (ev.os == OS_SKP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            skp_q   <= 1'b0;
            vld_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            skp_q   <= skp_d;
            vld_q   <= rx_valid;
        end
    end

endmodule

// File: rtl/rxfm_status.sv
module rxfm_status
    import rxfm_pkg::*;
#(
    parameter int                ADDR_W        = 12,
    parameter int                DATA_W        = 32,
    parameter logic [ADDR_W-1:0] STATUS_OFFSET = 12'h238
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ERR_BITS-1:0] set_vec,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [ERR_BITS-1:0] status_q
);

    localparam int RSV_W = DATA_W - ERR_BITS;

    logic                hit;
    logic [ERR_BITS-1:0] clr_mask;
    logic                unused_wdata_hi;

    assign hit             = (reg_addr == STATUS_OFFSET);
    assign clr_mask        = (hit && reg_wr) ? reg_wdata[ERR_BITS-1:0] : '0;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:ERR_BITS];
    assign reg_rdata       = hit ? {{RSV_W{1'b0}}, status_q} : '0;

    always_ff @(posedge clk) begin
        if (rst)
            status_q <= '0;
        else
            status_q <= (status_q & ~clr_mask) | set_vec;
    end

endmodule

// File: rtl/rx_frame_err_mon.sv
module rx_frame_err_mon
    import rxfm_pkg::*;
#(
    parameter int                ADDR_W        = 12,
    parameter int                DATA_W        = 32,
    parameter logic [ADDR_W-1:0] STATUS_OFFSET = 12'h238
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              blk_start,
    input  logic [1:0]        blk_sync,
    input  logic [2:0]        blk_os,
    input  logic              eds_tok,
    input  logic              bad_tok,
    input  logic              rx_valid,
    input  logic [2:0]        rx_status,
    input  logic              in_tlp,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    blk_evt_t            ev;
    logic [ERR_BITS-1:0] set_vec;
    logic [ERR_BITS-1:0] status_w;
    strm_state_e         state_w;

    always_comb begin
        ev.start   = blk_start;
        ev.sync    = blk_sync;
        ev.os      = os_kind_e'(blk_os);
        ev.eds     = eds_tok;
        ev.bad_tok = bad_tok;
    end

    rxfm_tracker u_trk (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .rx_valid  (rx_valid),
        .rx_status (rx_status),
        .in_tlp    (in_tlp),
        .set_vec   (set_vec),
        .state_q   (state_w)
    );

    rxfm_status #(
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .STATUS_OFFSET (STATUS_OFFSET)
    ) u_sts (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_vec),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .status_q  (status_w)
    );

endmodule

// File: rtl/rxfm_checker.sv
module rxfm_checker
    import rxfm_pkg::*;
#(
    parameter int                ADDR_W        = 12,
    parameter int                DATA_W        = 32,
    parameter logic [ADDR_W-1:0] STATUS_OFFSET = 12'h238
) (
    input logic                clk,
    input logic                rst,
    input logic [ERR_BITS-1:0] set_vec,
    input logic [ERR_BITS-1:0] status_q,
    input strm_state_e         state_q,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wr,
    input logic [ERR_BITS-1:0] wdata_lo,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic                blk_start,
    input logic [1:0]          blk_sync,
    input logic [2:0]          rx_status,
    input logic                in_tlp
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (reg_rdata[DATA_W-1:ERR_BITS] == '0)); // R1

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == STATUS_OFFSET)
        |=> ((status_q & $past(wdata_lo) & ~$past(set_vec)) == '0)); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0)); // R2

    AST_BAD_SYNC: assert property (@(posedge clk) disable iff (rst)
        (blk_start && (blk_sync == 2'b00 || blk_sync == 2'b11))
        |=> status_q[B_BAD_SYNC]); // R3

    AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (|set_vec[ERR_BITS-1:1]) |=> (state_q == ST_IDLE)); // R4

    AST_PHY_ERR: assert property (@(posedge clk) disable iff (rst)
        (in_tlp && rx_status[2]) |=> status_q[B_PHY_ERR]); // R11

endmodule

bind rx_frame_err_mon rxfm_checker #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .STATUS_OFFSET (STATUS_OFFSET)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (set_vec),
    .status_q  (status_w),
    .state_q   (state_w),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .wdata_lo  (reg_wdata[8:0]),
    .reg_rdata (reg_rdata),
    .blk_start (blk_start),
    .blk_sync  (blk_sync),
    .rx_status (rx_status),
    .in_tlp    (in_tlp)
);

// File: tb/sim_rx_frame_err_mon.sv
module sim_rx_frame_err_mon;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] OFS   = 12'h238;
    localparam logic [ADDR_W-1:0] OTHER = 12'h23C;

    // vector: st,sync,os,eds,bad,vld,rxs,tlp,wr,wdata[8:0],exp[8:0]
    function automatic logic [31:0] v(
        input logic st, input logic [1:0] sy, input logic [2:0] os,
        input logic ed, input logic bd, input logic vl, input logic [2:0] rs,
        input logic tl, input logic wr, input logic [8:0] wd, input logic [8:0] ex);
        return {st, sy, os, ed, bd, vl, rs, tl, wr, wd, ex};
    endfunction

    localparam int NV = 36;
    localparam logic [31:0] VEC [NV] = '{
        v(0, 2'b01, 3'd0, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h000), // 0  idle
        v(1, 2'b10, 3'd3, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h000), // 1  SDS starts stream
        v(1, 2'b01, 3'd0, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h000), // 2  data in stream
        v(0, 2'b01, 3'd0, 1, 0, 1, 3'd0, 0, 0, 9'h000, 9'h000), // 3  EDS
        v(1, 2'b10, 3'd1, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h000), // 4  EIOS legal
        v(1, 2'b10, 3'd3, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h000), // 5  SDS
        v(0, 2'b01, 3'd0, 1, 0, 1, 3'd0, 0, 0, 9'h000, 9'h000), // 6  EDS
        v(1, 2'b01, 3'd0, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h008), // 7  data after EDS
        v(1, 2'b10, 3'd3, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h008), // 8  SDS
        v(0, 2'b01, 3'd0, 1, 0, 1, 3'd0, 0, 0, 9'h000, 9'h008), // 9  EDS
        v(1, 2'b10, 3'd4, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h00C), // 10 other OS after EDS
        v(0, 2'b01, 3'd0, 0, 0, 1, 3'd0, 0, 1, 9'h00C, 9'h000), // 11 clear
        v(1, 2'b10, 3'd3, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h000), // 12 SDS
        v(1, 2'b10, 3'd0, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h010), // 13 SKP without EDS
        v(1, 2'b10, 3'd1, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h012), // 14 OS after SKP
        v(1, 2'b10, 3'd3, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h012), // 15 SDS
        v(1, 2'b10, 3'd3, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h052), // 16 SDS twice
        v(1, 2'b10, 3'd3, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h052), // 17 SDS
        v(0, 2'b01, 3'd0, 0, 1, 1, 3'd0, 1, 0, 9'h000, 9'h072), // 18 bad token in TLP
        v(1, 2'b10, 3'd3, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h072), // 19 SDS
        v(0, 2'b01, 3'd0, 0, 0, 0, 3'd0, 0, 0, 9'h000, 9'h172), // 20 valid drops
        v(0, 2'b01, 3'd0, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h172), // 21 valid back
        v(1, 2'b00, 3'd0, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h1F2), // 22 sync 00
        v(0, 2'b01, 3'd0, 0, 0, 1, 3'd5, 1, 0, 9'h000, 9'h1F3), // 23 PHY error
        v(0, 2'b01, 3'd0, 0, 0, 1, 3'd4, 1, 1, 9'h1F3, 9'h001), // 24 clear vs set
        v(0, 2'b01, 3'd0, 0, 0, 1, 3'd0, 0, 1, 9'h001, 9'h000), // 25 clear
        v(0, 2'b01, 3'd0, 0, 1, 1, 3'd0, 1, 0, 9'h000, 9'h000), // 26 bad token idle
        v(0, 2'b01, 3'd0, 0, 0, 1, 3'd6, 0, 0, 9'h000, 9'h000), // 27 status no TLP
        v(1, 2'b11, 3'd0, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h080), // 28 sync 11
        v(0, 2'b01, 3'd0, 0, 0, 1, 3'd0, 0, 1, 9'h080, 9'h000), // 29 clear
        v(1, 2'b10, 3'd3, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h000), // 30 SDS
        v(0, 2'b01, 3'd0, 1, 0, 1, 3'd0, 0, 0, 9'h000, 9'h000), // 31 EDS
        v(1, 2'b10, 3'd0, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h000), // 32 SKP after EDS
        v(1, 2'b01, 3'd0, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h000), // 33 data after SKP
        v(0, 2'b01, 3'd0, 0, 0, 0, 3'd0, 0, 0, 9'h000, 9'h000), // 34 valid drop idle
        v(0, 2'b01, 3'd0, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h000)  // 35
    };

    localparam string TAG [NV] = '{
        "R1", "R4", "R4", "R4", "R5", "R4", "R4", "R6", "R4", "R4",
        "R5", "R2", "R4", "R7", "R8", "R4", "R7", "R4", "R9", "R4",
        "R10", "R10", "R3", "R11", "R2", "R2", "R9", "R11", "R3", "R2",
        "R4", "R4", "R5", "R8", "R10", "R10"
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              blk_start, eds_tok, bad_tok, rx_valid, in_tlp, reg_wr;
    logic [1:0]        blk_sync;
    logic [2:0]        blk_os, rx_status;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] reg_wdata, reg_rdata;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    rx_frame_err_mon #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_OFFSET(OFS)) u0 (
        .clk(clk), .rst(rst), .blk_start(blk_start), .blk_sync(blk_sync),
        .blk_os(blk_os), .eds_tok(eds_tok), .bad_tok(bad_tok),
        .rx_valid(rx_valid), .rx_status(rx_status), .in_tlp(in_tlp),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected=%h", req, reg_rdata, exp);
        end
    endtask

    task automatic idle_inputs();
        blk_start = 0; blk_sync = 2'b01; blk_os = 3'd0; eds_tok = 0;
        bad_tok = 0; rx_valid = 1; rx_status = 3'd0; in_tlp = 0;
        reg_wr = 0; reg_wdata = '0; reg_addr = OFS;
    endtask

    task automatic apply(input logic [31:0] x);
        @(negedge clk);
        {blk_start, blk_sync, blk_os, eds_tok, bad_tok, rx_valid,
         rx_status, in_tlp, reg_wr} = x[31:18];
        reg_wdata = {{(DATA_W-9){1'b0}}, x[17:9]};
        reg_addr  = OFS;
        @(posedge clk);
        #2;
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1 check("R1", '0);                  // reset state

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check(TAG[i], {{(DATA_W-9){1'b0}}, VEC[i][8:0]});
        end

        // R3 then foreign address read and write (R1, R2)
        apply(v(1, 2'b00, 3'd0, 0, 0, 1, 3'd0, 0, 0, 9'h000, 9'h080));
        check("R3", 32'h080);
        @(negedge clk);
        idle_inputs();
        reg_addr = OTHER;
        #1 check("R1", '0);                  // other address reads 0
        reg_wr = 1; reg_wdata = 32'hFFFF_FFFF;
        @(posedge clk); #2;
        @(negedge clk);
        reg_wr = 0; reg_addr = OFS;
        #1 check("R2", 32'h080);             // foreign write ignored

        // R1: reserved bits read 0 after writing all ones
        reg_wr = 1; reg_wdata = 32'hFFFF_FE00;
        @(posedge clk); #2;
        check("R1", 32'h080);

        // R1: reset mid-run clears status
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(posedge clk); #2;
        @(negedge clk);
        rst = 1'b0;
        #1 check("R1", '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule